// File: doc/BRIEF.md
# ECG Front-End SPI Emulator

This block stands in for an eight-channel, 24-bit ECG acquisition front end, so that a controller design can be brought up and regression-tested without the real analog device. It is an SPI slave running in the system clock domain. The bus uses clock idle low, MOSI sampled on the falling SCLK edge, MISO changed after the rising edge, and bytes sent MSB first. Through that bus it exposes a bank of 26 byte-wide configuration registers. A controller can read or write any run of consecutive registers in one chip-select session.

While the emulator is awake, an internal timer latches a new sample frame every `SAMPLE_PERIOD` clock cycles and pulls the active-low data-ready output low. A frame is 27 bytes: three status bytes followed by eight 24-bit channel words. The channel words come from per-channel counters, so a checker can predict every sample. After a stream-on command, each chip-select session clocks out the latest frame from its first byte. A stream-off command returns the emulator to command decoding. A sleep command stops frame production. A wake command restarts it after a programmable settling delay.

Top module: `ecg_fe_emu`

## Requirements
- R1: After reset, `data_rdy_n` is 1 and `spi_miso` is 0, register 0 reads 0x92 and registers 1..25 read 0x00.
- R2: SPI framing: MOSI is sampled on falling SCLK edges and MISO changes only after rising edges, MSB first. A rising `spi_cs_n` restarts byte framing and the command parser, and MISO is 0 while `spi_cs_n` is high.
- R3: Byte 0x40|a followed by byte n-1 (low 5 bits used) writes the next n bytes into registers a, a+1, ... a+n-1.
- R4: Byte 0x20|a followed by byte n-1 makes the next n bytes on MISO carry registers a .. a+n-1. MISO carries 0x00 during the opcode and count bytes.
- R5: Register 0 is a read-only identity value 0x92 and writes to it are dropped. Addresses 26..31 read 0x00 and writes to them are dropped.
- R6: While awake, a new frame is latched every `SAMPLE_PERIOD` cycles and `data_rdy_n` falls at that point. It is high in the cycle before each new frame. It returns high on the first rising SCLK edge of a chip-select session.
- R7: Frame byte order: 0xC0, 0x00, 0x00, then channels 0..7, each 24 bits MSB first. In frame k (k = number of frames latched since reset before it, starting at 0), channel i holds k*(i+1) mod 2^24.
- R8: Byte 0x10 enters stream mode, in which every session shifts out the current frame starting at its first byte and every byte except 0x11 is ignored, including register writes. Byte 0x11 leaves stream mode.
- R9: Byte 0x04 enters sleep: `data_rdy_n` goes and stays high, no frame is latched, and the channel counters hold.
- R10: Byte 0x02 during sleep starts a `WAKE_DELAY`-cycle settling phase. After it, the sample timer restarts from zero, so the next frame comes `WAKE_DELAY + SAMPLE_PERIOD` cycles (plus synchroniser latency) after the command. Channel counters continue from their held values.
- R11: Undefined opcodes are ignored, and bytes after a completed burst in the same session are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | SPI serial clock from the controller |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller (registered) |
| data_rdy_n | output | 1 | Active-low new-frame indication (registered) |

## Verification
The assertions assume a controller that keeps SCLK well below the system clock: each SCLK half period lasts several clock cycles, so every edge survives the two-stage synchroniser and register read data is ready before the next byte begins. They also assume that `spi_cs_n` goes high between commands and that a frame is read in full before the next one is latched. The stimulus uses ten-cycle SCLK half periods and a gap after every session, and it starts each frame read right after `data_rdy_n` falls. A 27-byte read therefore ends well inside the sample period the bench selects.

// File: rtl/efe_pkg.sv
package efe_pkg;
  // single-byte commands
  localparam logic [7:0] OP_WAKE       = 8'h02;
  localparam logic [7:0] OP_SLEEP      = 8'h04;
  localparam logic [7:0] OP_STREAM_ON  = 8'h10;
  localparam logic [7:0] OP_STREAM_OFF = 8'h11;
  // register access groups, low 5 bits carry the start address
  localparam logic [2:0] OPG_RD_GRP    = 3'b001;
  localparam logic [2:0] OPG_WR_GRP    = 3'b010;

  localparam logic [7:0]  DEV_ID      = 8'h92;
  localparam logic [23:0] STATUS_WORD = 24'hC00000;

  typedef enum logic [1:0] {PW_RUN, PW_SLEEP, PW_WAKING} pwr_t;
  typedef enum logic [1:0] {CS_OPCODE, CS_COUNT, CS_BURST, CS_DRAIN} cmd_st_t;
endpackage

// File: rtl/efe_spi_link.sv
module efe_spi_link (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       first_edge,
  output logic       sess_end
);
  logic cs_m, cs_s, cs_q;
  logic sclk_m, sclk_s, sclk_q;
  logic mosi_m, mosi_s;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic seen;
  logic rise, fall;

  assign rise = !cs_s && sclk_s && !sclk_q;
  assign fall = !cs_s && !sclk_s && sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_m <= 1'b1; cs_s <= 1'b1; cs_q <= 1'b1;
      sclk_m <= 1'b0; sclk_s <= 1'b0; sclk_q <= 1'b0;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
      bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0; rx_byte <= '0;
      rx_valid <= 1'b0; first_edge <= 1'b0; sess_end <= 1'b0;
      seen <= 1'b0; miso <= 1'b0;
    end else begin
      cs_m <= cs_n;   cs_s <= cs_m;   cs_q <= cs_s;
      sclk_m <= sclk; sclk_s <= sclk_m; sclk_q <= sclk_s;
      mosi_m <= mosi; mosi_s <= mosi_m;
      rx_valid <= 1'b0;
      first_edge <= 1'b0;
      sess_end <= cs_s && !cs_q;
      if (cs_s) begin
        bit_cnt <= '0;
        seen <= 1'b0;
        miso <= 1'b0;
      end else begin
        if (rise) begin
          if (!seen) first_edge <= 1'b1;
          seen <= 1'b1;
          if (bit_cnt == 3'd0) begin
            miso  <= tx_byte[7];
            tx_sh <= {tx_byte[6:0], 1'b0};
          end else begin
            miso  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
        if (fall) begin
          rx_sh   <= {rx_sh[6:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_valid <= 1'b1;
            rx_byte  <= {rx_sh[6:0], mosi_s};
          end
        end
      end
    end
  end

  // R2
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise && !cs_s) |=> $stable(miso));
endmodule

// File: rtl/efe_regbank.sv
module efe_regbank #(
  parameter int NREG = 26,
  parameter int AW   = 5,
  parameter int DW   = 8,
  parameter logic [DW-1:0] ID_VALUE = 8'h92
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (rd_addr == '0)   rd_data <= ID_VALUE;
    else if (rd_addr <= LAST) rd_data <= regs[rd_addr];
    else                      rd_data <= '0;
  end

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != '0 && wr_addr <= LAST));
endmodule

// File: rtl/efe_frame_gen.sv
module efe_frame_gen
  import efe_pkg::*;
#(
  parameter int NCH           = 8,
  parameter int SBITS         = 24,
  parameter int SAMPLE_PERIOD = 100000,
  parameter int WAKE_DELAY    = 1000,
  parameter int IDXW          = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_req,
  input  logic            wake_req,
  input  logic            rdy_clr,
  input  logic [IDXW-1:0] byte_idx,
  output logic [7:0]      frame_byte,
  output logic            data_rdy_n
);
  localparam int STAT_BYTES  = 3;
  localparam int FRAME_BYTES = STAT_BYTES + NCH * SBITS / 8;
  localparam int FRAME_BITS  = FRAME_BYTES * 8;
  localparam int BPW         = $clog2(FRAME_BITS);
  localparam int TW          = $clog2(SAMPLE_PERIOD);
  localparam int WW          = $clog2(WAKE_DELAY + 1);

  pwr_t            pwr;
  logic [TW-1:0]   tick_cnt;
  logic [WW-1:0]   wake_cnt;
  logic            tick, pre_tick;
  logic [SBITS-1:0] ch_cnt [NCH];
  logic [SBITS-1:0] snap   [NCH];
  logic [FRAME_BITS-1:0] frame_vec;
  logic [BPW-1:0]  bitpos;

  assign tick     = (pwr == PW_RUN) && (tick_cnt == TW'(SAMPLE_PERIOD - 1));
  assign pre_tick = (pwr == PW_RUN) && (tick_cnt == TW'(SAMPLE_PERIOD - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= PW_RUN;
      tick_cnt <= '0;
      wake_cnt <= '0;
      data_rdy_n <= 1'b1;
    end else if (sleep_req) begin
      pwr <= PW_SLEEP;
      tick_cnt <= '0;
      data_rdy_n <= 1'b1;
    end else begin
      case (pwr)
        PW_RUN: begin
          tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
          if (tick)         data_rdy_n <= 1'b0;
          else if (pre_tick) data_rdy_n <= 1'b1;
          else if (rdy_clr) data_rdy_n <= 1'b1;
        end
        PW_SLEEP: begin
          if (wake_req) begin
            pwr <= PW_WAKING;
            wake_cnt <= '0;
          end
        end
        default: begin
          if (wake_cnt == WW'(WAKE_DELAY - 1)) begin
            pwr <= PW_RUN;
            tick_cnt <= '0;
          end else begin
            wake_cnt <= wake_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        ch_cnt[i] <= '0;
        snap[i]   <= '0;
      end
    end else if (tick) begin
      for (int i = 0; i < NCH; i++) begin
        snap[i]   <= ch_cnt[i];
        ch_cnt[i] <= ch_cnt[i] + SBITS'(i + 1);
      end
    end
  end

  assign frame_vec[FRAME_BITS-1 -: 24] = STATUS_WORD;
  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign frame_vec[(NCH-1-g)*SBITS +: SBITS] = snap[g];
  end

  always_comb begin
    bitpos = BPW'((FRAME_BYTES - 1 - int'(byte_idx)) * 8);
    if (byte_idx < IDXW'(FRAME_BYTES)) frame_byte = frame_vec[bitpos +: 8];
    else                               frame_byte = 8'h00;
  end

  // R9
  sleep_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr != PW_RUN) |-> data_rdy_n);
  // R6
  rdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(data_rdy_n) |-> $past(pwr == PW_RUN));
endmodule

// File: rtl/ecg_fe_emu.sv
module ecg_fe_emu
  import efe_pkg::*;
#(
  parameter int NREG          = 26,
  parameter int NCH           = 8,
  parameter int SBITS         = 24,
  parameter int SAMPLE_PERIOD = 100000,
  parameter int WAKE_DELAY    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic data_rdy_n
);
  localparam int AW          = 5;
  localparam int FRAME_BYTES = 3 + NCH * SBITS / 8;
  localparam int IDXW        = $clog2(FRAME_BYTES + 1);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic            rx_valid, first_edge, sess_end;
  logic [7:0]      rx_byte, tx_byte, rd_data, frame_byte;
  cmd_st_t         cmd_st;
  logic            streaming, is_wr;
  logic [AW-1:0]   addr, left;
  logic [IDXW-1:0] frame_idx;
  logic            sleep_req, wake_req;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [7:0]      wr_data;

  efe_spi_link u_link (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .tx_byte(tx_byte), .miso(spi_miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .first_edge(first_edge), .sess_end(sess_end)
  );

  efe_regbank #(.NREG(NREG), .AW(AW), .DW(8), .ID_VALUE(DEV_ID)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr), .rd_data(rd_data)
  );

  efe_frame_gen #(
    .NCH(NCH), .SBITS(SBITS), .SAMPLE_PERIOD(SAMPLE_PERIOD),
    .WAKE_DELAY(WAKE_DELAY), .IDXW(IDXW)
  ) u_frame (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .rdy_clr(first_edge), .byte_idx(frame_idx), .frame_byte(frame_byte),
    .data_rdy_n(data_rdy_n)
  );

  always_comb begin
    if (streaming)                              tx_byte = frame_byte;
    else if (cmd_st == CS_BURST && !is_wr)      tx_byte = rd_data;
    else                                        tx_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_st <= CS_OPCODE;
      streaming <= 1'b0;
      is_wr <= 1'b0;
      addr <= '0;
      left <= '0;
      frame_idx <= '0;
      sleep_req <= 1'b0;
      wake_req <= 1'b0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sleep_req <= 1'b0;
      wake_req <= 1'b0;
      wr_en <= 1'b0;
      if (sess_end) begin
        cmd_st <= CS_OPCODE;
        frame_idx <= '0;
      end else if (rx_valid) begin
        if (streaming) begin
          if (rx_byte == OP_STREAM_OFF) streaming <= 1'b0;
          if (frame_idx != IDXW'(FRAME_BYTES)) frame_idx <= frame_idx + 1'b1;
        end else begin
          case (cmd_st)
            CS_OPCODE: begin
              if (rx_byte[7:5] == OPG_RD_GRP || rx_byte[7:5] == OPG_WR_GRP) begin
                addr   <= rx_byte[4:0];
                is_wr  <= (rx_byte[7:5] == OPG_WR_GRP);
                cmd_st <= CS_COUNT;
              end else if (rx_byte == OP_STREAM_ON) begin
                streaming <= 1'b1;
                frame_idx <= '0;
              end else if (rx_byte == OP_SLEEP) begin
                sleep_req <= 1'b1;
              end else if (rx_byte == OP_WAKE) begin
                wake_req <= 1'b1;
              end
            end
            CS_COUNT: begin
              left   <= rx_byte[4:0];
              cmd_st <= CS_BURST;
            end
            CS_BURST: begin
              if (is_wr && addr != '0 && addr <= LAST) begin
                wr_en   <= 1'b1;
                wr_addr <= addr;
                wr_data <= rx_byte;
              end
              addr <= addr + 1'b1;
              if (left == '0) cmd_st <= CS_DRAIN;
              else            left <= left - 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R8
  no_wr_stream_chk: assert property (@(posedge clk) disable iff (rst)
    streaming |-> !wr_en);
  // R11
  drain_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_st == CS_DRAIN) |=> !wr_en);
endmodule

// File: tb/ecg_fe_emu_test.sv
module ecg_fe_emu_test;
  localparam int SP   = 6000;
  localparam int WD   = 2000;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, rdy_n;

  always #10 clk = ~clk;

  ecg_fe_emu #(.SAMPLE_PERIOD(SP), .WAKE_DELAY(WD)) uut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .data_rdy_n(rdy_n)
  );

  typedef struct {
    logic [7:0] val;
    bit         chk;
    string      req;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] got_q[$];
  event       byte_done;
  int total = 0, bad = 0;
  int cyc = 0;
  int falls = 0, last_fall = 0, prev_fall = 0;
  int last_sclk_fall = 0;
  logic rdy_prev = 1'b1;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && rdy_prev && !rdy_n) begin
      falls++;
      prev_fall = last_fall;
      last_fall = cyc;
    end
    rdy_prev = rdy_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(byte_done);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        if (e.chk) check(e.req, {24'h0, g}, {24'h0, e.val});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, input bit chk, input logic [7:0] expv, input string req);
    logic [7:0] r;
    exp_t e;
    e.val = expv; e.chk = chk; e.req = req;
    exp_q.push_back(e);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b1;
      mosi = b[i];
      wait_clk(HALF);
      r[i] = miso;
      sclk = 1'b0;
      last_sclk_fall = cyc;
      wait_clk(HALF);
    end
    got_q.push_back(r);
    -> byte_done;
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_begin();
    xfer(op, 1'b0, 8'h00, "");
    cs_end();
  endtask

  task automatic rreg(input logic [4:0] a, input int n, input logic [7:0] e0, input logic [7:0] e1,
                      input logic [7:0] e2, input logic [7:0] e3, input string req);
    logic [7:0] ev [4];
    ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
    cs_begin();
    xfer({3'b001, a}, 1'b1, 8'h00, req);
    xfer(8'(n - 1), 1'b1, 8'h00, req);
    for (int i = 0; i < n; i++) xfer(8'h00, 1'b1, ev[i], req);
    cs_end();
  endtask

  task automatic wreg(input logic [4:0] a, input int n, input logic [7:0] d0, input logic [7:0] d1,
                      input logic [7:0] d2, input logic [7:0] d3);
    logic [7:0] dv [4];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    cs_begin();
    xfer({3'b010, a}, 1'b0, 8'h00, "");
    xfer(8'(n - 1), 1'b0, 8'h00, "");
    for (int i = 0; i < n; i++) xfer(dv[i], 1'b0, 8'h00, "");
    cs_end();
  endtask

  function automatic logic [7:0] frame_exp(input int k, input int b);
    logic [23:0] v;
    int ch;
    if (b == 0) return 8'hC0;
    if (b < 3) return 8'h00;
    ch = (b - 3) / 3;
    v = 24'(k * (ch + 1));
    case ((b - 3) % 3)
      0: return v[23:16];
      1: return v[15:8];
      default: return v[7:0];
    endcase
  endfunction

  task automatic wait_fall(input string req);
    int start;
    int t;
    start = falls;
    t = 0;
    while (falls == start && t < 3 * SP) begin
      wait_clk(1);
      t++;
    end
    if (falls == start) check(req, 32'd0, 32'd1);
  endtask

  task automatic read_frame(input int k, input string req);
    cs_begin();
    for (int b = 0; b < 27; b++) begin
      xfer(8'h00, 1'b1, frame_exp(k, b), req);
      // R6: first SCLK edge of the session releases data-ready
      if (b == 0) check("R6", {31'd0, rdy_n}, 32'd1);
    end
    cs_end();
  endtask

  initial begin
    wait_clk(190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int dt;
    int fcount;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    check("R1", {31'd0, rdy_n}, 32'd1);
    check("R1", {31'd0, miso}, 32'd0);
    rreg(5'd0, 1, 8'h92, 8'h00, 8'h00, 8'h00, "R1");
    rreg(5'd1, 3, 8'h00, 8'h00, 8'h00, 8'h00, "R1");
    // R3 / R4 burst write then burst read; R2 byte framing across sessions
    wreg(5'd1, 4, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    rreg(5'd1, 4, 8'hA1, 8'hB2, 8'hC3, 8'hD4, "R3");
    rreg(5'd2, 2, 8'hB2, 8'hC3, 8'h00, 8'h00, "R4");
    check("R2", {31'd0, miso}, 32'd0);
    // R5 read-only identity and out-of-range addresses
    wreg(5'd0, 1, 8'h55, 8'h00, 8'h00, 8'h00);
    rreg(5'd0, 1, 8'h92, 8'h00, 8'h00, 8'h00, "R5");
    wreg(5'd25, 3, 8'h11, 8'h22, 8'h33, 8'h00);
    rreg(5'd25, 3, 8'h11, 8'h00, 8'h00, 8'h00, "R5");
    // R11 undefined opcode, then extra bytes after a burst
    cmd1(8'h0F);
    rreg(5'd1, 1, 8'hA1, 8'h00, 8'h00, 8'h00, "R11");
    cs_begin();
    xfer(8'h42, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b0, 8'h00, "");
    xfer(8'h77, 1'b0, 8'h00, "");
    xfer(8'h99, 1'b0, 8'h00, "");
    cs_end();
    rreg(5'd2, 2, 8'h77, 8'hC3, 8'h00, 8'h00, "R11");
    // R6 period between frames
    wait_fall("R6");
    wait_fall("R6");
    check("R6", last_fall - prev_fall, SP);
    // R7 / R8 stream mode reads
    cmd1(8'h10);
    wait_fall("R8");
    read_frame(falls - 1, "R7");
    wait_fall("R8");
    read_frame(falls - 1, "R8");
    // R8 register write ignored while streaming
    cs_begin();
    xfer(8'h41, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b0, 8'h00, "");
    xfer(8'h5A, 1'b0, 8'h00, "");
    cs_end();
    cmd1(8'h11);
    rreg(5'd1, 1, 8'hA1, 8'h00, 8'h00, 8'h00, "R8");
    // R9 sleep
    cmd1(8'h04);
    wait_clk(20);
    fcount = falls;
    check("R9", {31'd0, rdy_n}, 32'd1);
    wait_clk(3 * SP);
    check("R9", falls, fcount);
    check("R9", {31'd0, rdy_n}, 32'd1);
    // R10 wake with settling delay
    cs_begin();
    xfer(8'h02, 1'b0, 8'h00, "");
    dt = last_sclk_fall;
    cs_end();
    wait_fall("R10");
    dt = last_fall - dt;
    check("R10", {31'd0, (dt >= WD + SP) && (dt <= WD + SP + 20)}, 32'd1);
    cmd1(8'h10);
    wait_fall("R10");
    read_frame(falls - 1, "R10");
    cmd1(8'h11);
    wait_clk(20);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule